// File: doc/BRIEF.md
# Multi-Channel Comparator Qualification Filter

This block cleans up the raw digital outputs of a battery charger's protection and threshold comparators before the charge controller acts on them. It handles eight channels: input overvoltage, die over-temperature, thermistor out of window, input-below-battery (sleep), battery-low, recharge request, battery short and low charge current. Each raw bit passes through a two-flop synchronizer. It then goes to its own qualifier, which changes the channel's flag only after the new level has been present for a set number of time-base ticks. The assert direction and the clear direction each have their own count and their own time base.

Two tick inputs set the time bases, one pulse per microsecond and one per millisecond. The qualifier counts only the ticks of the base chosen for the direction it is currently qualifying. A combined permit output is high only when none of the four blocking channels is flagged: overvoltage, over-temperature, thermistor and sleep. After reset every flag takes its safe value and the permit is low. Normal flag values then come in as each channel qualifies.

Top module: `cmp_deglitch`

## Requirements
- R1: While reset is asserted, and after its release until a channel qualifies, flags_o equals 8'hDF (bit 5, recharge, low; all other bits high) and fault_ok_o is low.
- R2: Each raw input is resampled through two flops. A raw change made just before clock edge k is first visible to its qualifier at edge k+2, so with a tick on every cycle a one-tick channel's flag changes at edge k+2.
- R3: A flag changes to the synchronized level only on a clock edge where the time-base tick for that direction is high and the level has differed from the flag on N such ticks, N counting the current one. On that edge the count clears.
- R4: If the synchronized level equals the flag on any cycle, the pending count clears. A later attempt then needs the full N ticks again.
- R5: A tick of the time base not selected for the current direction does not advance the count.
- R6: Bit 0 (overvoltage) asserts after 1 ms-tick and clears after 20 ms-ticks. Bit 1 (over-temperature) asserts after 100 µs-ticks and clears after 10 ms-ticks.
- R7: Bit 2 (thermistor out of window) asserts after 400 ms-ticks and clears after 20 ms-ticks. Bit 3 (sleep) asserts after 100 ms-ticks and clears after 30 ms-ticks.
- R8: Bit 4 (battery-low) takes 25 ms-ticks and bit 5 (recharge) takes 10 ms-ticks, in both directions. Bits 6 (battery short) and 7 (low current) take 1 µs-tick in both directions.
- R9: fault_ok_o is high exactly when flags_o[3:0] are all low, and it follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_us_i | input | 1 | One-cycle pulse per microsecond |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| raw_i | input | 8 | Unfiltered comparator outputs, one bit per channel, high = condition present |
| flags_o | output | 8 | Qualified channel flags |
| fault_ok_o | output | 1 | High when no blocking channel is flagged |

## Verification
The count in a qualifier is hidden, but a fault in it shows at the ports as a flag that moves one tick early or late, or that does not restart after a glitch. So the bench counts the ticks it gives each channel. It checks that the flag is still held after N−1 ticks and has moved after the Nth, and it pulses the unused time base in between. A behavioural model compares every flag and the permit on every clock. It catches a wrong synchronizer depth within three cycles, and a wrong reset value, direction select or tick select on the first qualification that uses it.

// File: rtl/cmp_deglitch_pkg.sv
// Shared constants for the comparator qualification filter.
// Assumes the channel order below; the permit mask depends on it.
package cmp_deglitch_pkg;

    localparam int unsigned NCH = 8;

    localparam int unsigned CH_OVP   = 0;
    localparam int unsigned CH_HOT   = 1;
    localparam int unsigned CH_NTC   = 2;
    localparam int unsigned CH_SLEEP = 3;
    localparam int unsigned CH_BLOW  = 4;
    localparam int unsigned CH_RECH  = 5;
    localparam int unsigned CH_SHORT = 6;
    localparam int unsigned CH_ILOW  = 7;

    // Channels whose flag blocks charging.
    localparam logic [NCH-1:0] BLOCK_MASK =
        (NCH'(1) << CH_OVP) | (NCH'(1) << CH_HOT) |
        (NCH'(1) << CH_NTC) | (NCH'(1) << CH_SLEEP);

endpackage

// File: rtl/cmp_deglitch_sync.sv
// Multi-bit resynchronizer: each raw comparator bit passes through
// STAGES flops. Assumes the bits are unrelated to each other, so no
// coherency between them is kept. Resets to zero.
module cmp_deglitch_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cmp_deglitch_chan.sv
// One qualifier channel. The flag follows lvl_i only after lvl_i has
// differed from it for RISE_N (0->1) or FALL_N (1->0) ticks of the
// time base chosen for that direction. Any cycle with lvl_i equal to the
// flag clears the count. Assumes RISE_N and FALL_N are at least 1.
module cmp_deglitch_chan #(
    parameter int unsigned RISE_N  = 1,
    parameter int unsigned FALL_N  = 1,
    parameter bit          RISE_MS = 1'b0,
    parameter bit          FALL_MS = 1'b0,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_us_i,
    input  logic tick_ms_i,
    input  logic lvl_i,
    output logic flag_o
);

    localparam int unsigned MAXN = (RISE_N > FALL_N) ? RISE_N : FALL_N;
    localparam int unsigned CW   = $clog2(MAXN + 1);
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_N - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_N - 1);

    logic          flag_q;
    logic [CW-1:0] cnt_q;
    logic          differs;
    logic          tick_sel;
    logic [CW-1:0] last_cnt;

    // Pick the direction-dependent time base and terminal count.
    always_comb begin
        differs  = (lvl_i != flag_q);
        if (flag_q) begin
            tick_sel = FALL_MS ? tick_ms_i : tick_us_i;
            last_cnt = FALL_LAST;
        end else begin
            tick_sel = RISE_MS ? tick_ms_i : tick_us_i;
            last_cnt = RISE_LAST;
        end
    end

    // Count qualifying ticks and flip the flag on the last one.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= RST_VAL;
            cnt_q  <= '0;
        end else if (!differs) begin
            cnt_q  <= '0;
        end else if (tick_sel) begin
            if (cnt_q == last_cnt) begin
                flag_q <= lvl_i;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/cmp_deglitch_permit.sv
// Combines qualified flags into the charge permit: high when no flag
// selected by MASK is set. Purely combinational, so the permit moves in
// the same cycle as the flags.
module cmp_deglitch_permit #(
    parameter int unsigned     NCH  = 8,
    parameter logic [NCH-1:0]  MASK = '1
) (
    input  logic [NCH-1:0] flags_i,
    output logic           ok_o
);

    // Reduce the masked flags to one permit bit.
    always_comb begin
        ok_o = ~|(flags_i & MASK);
    end

endmodule

// File: rtl/cmp_deglitch.sv
// Top of the comparator qualification filter: synchronizer, one
// qualifier per channel with its own rise/fall counts and time bases,
// and the permit combiner. Assumes tick inputs are single-cycle pulses.
module cmp_deglitch
    import cmp_deglitch_pkg::*;
#(
    parameter int unsigned    SYNC_STAGES = 2,
    parameter int unsigned    RISE_N [NCH] = '{1, 100, 400, 100, 25, 10, 1, 1},
    parameter int unsigned    FALL_N [NCH] = '{20, 10, 20, 30, 25, 10, 1, 1},
    parameter logic [NCH-1:0] RISE_MS = 8'b0011_1101,
    parameter logic [NCH-1:0] FALL_MS = 8'b0011_1111,
    parameter logic [NCH-1:0] RST_VAL = 8'b1101_1111
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           tick_us_i,
    input  logic           tick_ms_i,
    input  logic [NCH-1:0] raw_i,
    output logic [NCH-1:0] flags_o,
    output logic           fault_ok_o
);

    logic [NCH-1:0] lvl_sync;

    cmp_deglitch_sync #(
        .W      (NCH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw_i),
        .q_o    (lvl_sync)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            cmp_deglitch_chan #(
                .RISE_N  (RISE_N[c]),
                .FALL_N  (FALL_N[c]),
                .RISE_MS (RISE_MS[c]),
                .FALL_MS (FALL_MS[c]),
                .RST_VAL (RST_VAL[c])
            ) u_chan (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .tick_us_i (tick_us_i),
                .tick_ms_i (tick_ms_i),
                .lvl_i     (lvl_sync[c]),
                .flag_o    (flags_o[c])
            );
        end
    endgenerate

    cmp_deglitch_permit #(
        .NCH  (NCH),
        .MASK (BLOCK_MASK)
    ) u_permit (
        .flags_i (flags_o),
        .ok_o    (fault_ok_o)
    );

endmodule

// File: rtl/cmp_deglitch_chk.sv
// Assertion checker for cmp_deglitch, attached by bind.
module cmp_deglitch_chk #(
    parameter int unsigned    NCH     = 8,
    parameter logic [NCH-1:0] RST_VAL = '0
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           tick_us_i,
    input logic           tick_ms_i,
    input logic [NCH-1:0] sync_i,
    input logic [NCH-1:0] flags_i,
    input logic           fault_ok_i
);

    // R1: a clock edge in reset leaves the safe flag pattern and no permit.
    a_r1_reset_safe: assert property (@(posedge clk_i)
        !rst_ni |=> (flags_i == RST_VAL) && !fault_ok_i);

    // R3: no flag moves on a cycle without any tick.
    a_r3_tick_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_i != $past(flags_i)) |-> $past(tick_us_i || tick_ms_i));

    // R4: a flag only ever moves to the level its qualifier was seeing.
    a_r4_moves_to_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_i != $past(flags_i)) |->
            (((flags_i ^ $past(flags_i)) & (flags_i ^ $past(sync_i))) == '0));

    // R6: overvoltage assertion is timed on the millisecond base.
    a_r6_ovp_rise_ms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flags_i[0]) |-> $past(tick_ms_i));

    // R6: over-temperature assertion is timed on the microsecond base.
    a_r6_hot_rise_us: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flags_i[1]) |-> $past(tick_us_i));

    // R9: a blocking flag and the permit are never high together.
    a_r9_permit_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_i[3:0] != 4'b0) |-> !fault_ok_i);

    // R9: with no blocking flag the permit is high.
    a_r9_permit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flags_i[3:0] == 4'b0) |-> fault_ok_i);

endmodule

bind cmp_deglitch cmp_deglitch_chk #(
    .NCH     (NCH),
    .RST_VAL (RST_VAL)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_us_i  (tick_us_i),
    .tick_ms_i  (tick_ms_i),
    .sync_i     (lvl_sync),
    .flags_i    (flags_o),
    .fault_ok_i (fault_ok_o)
);

// File: tb/tb_cmp_deglitch.sv
module tb_cmp_deglitch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tus = 1'b0;
    logic       tms = 1'b0;
    logic [7:0] raw = 8'h00;
    logic [7:0] flags;
    logic       fok;

    int compared = 0;
    int mismatched = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // Requirement tables (R6, R7, R8): counts and time base per direction.
    int unsigned RN [8] = '{1, 100, 400, 100, 25, 10, 1, 1};
    int unsigned FN [8] = '{20, 10, 20, 30, 25, 10, 1, 1};
    bit          RMS [8] = '{1, 0, 1, 1, 1, 1, 0, 0};
    bit          FMS [8] = '{1, 1, 1, 1, 1, 1, 0, 0};
    bit          RV [8]  = '{1, 1, 1, 1, 1, 0, 1, 1};

    always #4 clk = ~clk;

    cmp_deglitch dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_us_i  (tus),
        .tick_ms_i  (tms),
        .raw_i      (raw),
        .flags_o    (flags),
        .fault_ok_o (fok)
    );

    // Behavioural reference model.
    bit m_out [8];
    int m_cnt [8];
    bit m_pipe [8][$];

    always @(posedge clk) begin
        for (int c = 0; c < 8; c++) begin
            if (!rst_n) begin
                m_out[c] = RV[c];
                m_cnt[c] = 0;
                m_pipe[c] = '{1'b0, 1'b0};
            end else begin
                bit seen;
                bit tk;
                int lim;
                seen = m_pipe[c][1];
                tk  = m_out[c] ? (FMS[c] ? tms : tus) : (RMS[c] ? tms : tus);
                lim = m_out[c] ? FN[c] : RN[c];
                if (seen == m_out[c]) m_cnt[c] = 0;
                else if (tk) begin
                    m_cnt[c]++;
                    if (m_cnt[c] >= lim) begin
                        m_out[c] = seen;
                        m_cnt[c] = 0;
                    end
                end
                void'(m_pipe[c].pop_back());
                m_pipe[c].push_front(raw[c]);
            end
        end
        cmp_en = 1'b1;
    end

    function automatic logic [7:0] model_flags();
        logic [7:0] v;
        for (int c = 0; c < 8; c++) v[c] = m_out[c];
        return v;
    endfunction

    // Every-clock comparison against the model (R3, R9).
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            compared++;
            if (flags !== model_flags() || fok !== ~|model_flags()[3:0]) begin
                mismatched++;
                $display("FAIL R3/R9 model compare t=%0t act=%h/%b exp=%h/%b",
                         $time, flags, fok, model_flags(), ~|model_flags()[3:0]);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Drive a level on one channel and give it exactly n ticks of its base,
    // pulsing the other base between ticks (R5). Checks hold at n-1, move at n.
    task automatic qualify(input int ch, input bit lvl, input bit ms,
                           input int n, input string tag);
        @(negedge clk);
        raw[ch] = lvl; tus = 0; tms = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (ms) tms = 1; else tus = 1;
            @(negedge clk);
            tus = 0; tms = 0;
            if (ms) tus = 1; else tms = 1;
            @(negedge clk);
            tus = 0; tms = 0;
            @(negedge clk);
            if (i == n - 2) chk(flags[ch] == !lvl, {tag, " held before last tick"}, flags[ch], !lvl);
            if (i == n - 1) chk(flags[ch] == lvl, {tag, " moved on last tick"}, flags[ch], lvl);
        end
    endtask

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        chk(flags == 8'hDF, "R1 flags in reset", flags, 8'hDF);
        chk(fok == 1'b0, "R1 permit in reset", fok, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(flags == 8'hDF, "R1 flags held after release", flags, 8'hDF);

        // Settle all channels to idle.
        raw = 8'h00;
        repeat (3) @(negedge clk);
        tus = 1; tms = 1;
        repeat (500) @(negedge clk);
        tus = 0; tms = 0;
        @(negedge clk);
        chk(flags == 8'h00, "R3 all channels settled", flags, 0);
        chk(fok == 1'b1, "R9 permit with no faults", fok, 1);

        // R2: synchronizer depth with continuous microsecond ticks.
        tus = 1;
        raw[6] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(flags[6] == 1'b0, "R2 not yet through sync", flags[6], 0);
        @(negedge clk);
        chk(flags[6] == 1'b1, "R2 through sync", flags[6], 1);
        tus = 0;
        qualify(6, 0, 0, 1, "R8 short fall");

        qualify(0, 1, 1, 1, "R6 ovp rise");
        chk(fok == 1'b0, "R9 permit blocked by ovp", fok, 0);
        qualify(0, 0, 1, 20, "R6 ovp fall");
        chk(fok == 1'b1, "R9 permit back", fok, 1);
        qualify(1, 1, 0, 100, "R6 hot rise");
        qualify(1, 0, 1, 10, "R6 hot fall");

        // R4: glitch after 300 ticks restarts the 400-tick count.
        @(negedge clk);
        raw[2] = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            tms = 1; @(negedge clk); tms = 0; @(negedge clk);
        end
        raw[2] = 1'b0;
        @(negedge clk);
        raw[2] = 1'b1;
        qualify(2, 1, 1, 400, "R4 R7 ntc rise after glitch");
        qualify(2, 0, 1, 20, "R7 ntc fall");
        qualify(3, 1, 1, 100, "R7 sleep rise");
        qualify(3, 0, 1, 30, "R7 sleep fall");
        qualify(4, 1, 1, 25, "R8 batlow rise");
        chk(fok == 1'b1, "R9 batlow does not block", fok, 1);
        qualify(4, 0, 1, 25, "R8 batlow fall");
        qualify(5, 1, 1, 10, "R8 recharge rise");
        qualify(5, 0, 1, 10, "R8 recharge fall");
        qualify(7, 1, 0, 1, "R8 ilow rise");
        qualify(7, 0, 0, 1, "R8 ilow fall");

        // R5: ticks of the wrong base only; flag must stay put.
        @(negedge clk);
        raw[3] = 1'b1;
        tus = 1;
        repeat (200) @(negedge clk);
        tus = 0;
        chk(flags[3] == 1'b0, "R5 us ticks ignored by sleep", flags[3], 0);
        raw[3] = 1'b0;
        repeat (3) @(negedge clk);

        // Pseudo-random phase, checked by the every-clock model compare.
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) raw[lfsr[6:4]] = ~raw[lfsr[6:4]];
            tus = lfsr[7];
            tms = (lfsr[9:8] == 2'b00);
        end

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule